// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the software-facing register front end of an I/O interrupt controller serving 24 input pins. Software sees only two byte offsets. It stores an index in a select register, then reads or writes a data window. The window then reaches the register that the index names: an identification register, a version register, an arbitration register, or one 32-bit half of a 64-bit redirection entry.

The block owns the redirection table. Delivery logic next to it reads the whole table through a flat output. That logic also sets each entry's remote-request flag through a per-pin strobe. A pending-pin vector comes in from the pin sampling logic. When a table write lands on a pin whose pending bit is set, the block raises a one-cycle service request carrying that pin's index, so the delivery logic can evaluate the entry again.

Accesses are single-cycle requests carrying an address, a byte size and write data. Read data is registered and comes back one cycle later with a valid strobe.

Top module: `ioirq_regwin`

## Requirements
- R1: After reset the select register reads 0, the ID is 0, and no service request is raised. Every entry has its mask bit (bit 16) set and all its other bits clear.
- R2: A write to byte offset 0x00 stores data bits [7:0] as the select value. A read of offset 0x00 returns the select value in bits [7:0] and zero above.
- R3: With select 0x01, a window read returns pin count minus one in bits [23:16] and the version code (default 0x11) in bits [7:0]. All other bits are zero. A window write with select 0x01 changes no state.
- R4: With select 0x00, a window write loads the 4-bit ID from data bits [27:24]. A window read returns the ID in bits [27:24] and zero elsewhere.
- R5: With select 0x02, a window read returns the ID in bits [27:24]. A window write with select 0x02 changes no state.
- R6: For a select value of 0x10 or more, the entry index is (select - 0x10) >> 1. An odd select value reaches entry bits [63:32] and an even one reaches bits [31:0]. If the index is 24 or more, a write is discarded and a read returns 0.
- R7: A write to the low half of an entry forces that entry's remote-request flag (bit 14) to 0, whatever the data holds. A write to the high half leaves the flag unchanged.
- R8: A pulse on rirr_set_i[p] sets bit 14 of entry p. A low-half write to the same entry in the same cycle takes priority and leaves the flag at 0.
- R9: A table write to entry i while pend_i[i] is 1 raises svc_req_o in the next cycle for one cycle, with svc_idx_o = i. Any other access leaves svc_req_o low.
- R10: A write whose size is neither 4 nor 8 bytes changes no state and raises no service request.
- R11: Every read gives rd_valid_o one cycle later. The data is 0 for addresses other than 0x00 and 0x10, and for window reads while the select value is 0x03 to 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 8 | Byte offset; bits [7:0] of the address |
| req_size_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the read |
| rd_data_o | output | 32 | Read data |
| pend_i | input | 24 | Pending bit per pin, from the pin logic |
| rirr_set_i | input | 24 | Per-pin strobe that sets the remote-request flag |
| entries_o | output | 1536 | Whole table, entry p at bits [64p+63:64p] |
| svc_req_o | output | 1 | Service request pulse after a table write to a pending pin |
| svc_idx_o | output | 5 | Pin index that goes with svc_req_o |

## Verification
Directed sequences go through each select code, both halves of the first and last entries, and the first select value past the table. These cases tell a correct index computation apart from one that is off by one or swaps the halves. Remote-request flags are set through the strobe, then hit with high-half and low-half writes, including a write in the same cycle as the strobe. This separates the forced clear from a plain data write and shows which side wins the collision. Sizes 1, 2, 4 and 8 show which writes are accepted. Random traffic then mixes select values across the whole byte range with random pending vectors and strobes. Each service pulse, read value and table image is compared against a bench model.

// File: rtl/ioirq_pkg.sv
package ioirq_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned SEL_W   = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ENTRY_W = 2 * DATA_W;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned ID_LSB  = 24;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned RIRR_BIT = 14;

  localparam logic [ADDR_W-1:0] OFS_SEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_WIN = 8'h10;

  localparam logic [SEL_W-1:0] SEL_ID       = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VER      = 8'h01;
  localparam logic [SEL_W-1:0] SEL_ARB      = 8'h02;
  localparam logic [SEL_W-1:0] SEL_TBL_BASE = 8'h10;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << MASK_BIT;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_TBL
  } tgt_e;
endpackage

// File: rtl/ioirq_decode.sv
module ioirq_decode
  import ioirq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  input  logic [SEL_W-1:0]  sel_i,
  output tgt_e              tgt_o,
  output logic              hit_sel_o,
  output logic              hit_win_o,
  output logic              rd_en_o,
  output logic              sel_we_o,
  output logic              id_we_o,
  output logic              tbl_we_o,
  output logic              tbl_hi_o,
  output logic [IDX_W-1:0]  tbl_idx_o
);
  logic             size_ok;
  logic             wr_ok;
  logic [SEL_W-1:0] raw_idx;
  logic             in_tbl;

  assign size_ok   = (size_i == 4'd4) || (size_i == 4'd8);
  assign wr_ok     = valid_i && write_i && size_ok;
  assign hit_sel_o = (addr_i == OFS_SEL);
  assign hit_win_o = (addr_i == OFS_WIN);
  assign rd_en_o   = valid_i && !write_i;

  assign raw_idx   = (sel_i - SEL_TBL_BASE) >> 1;
  assign in_tbl    = (sel_i >= SEL_TBL_BASE) && (raw_idx < SEL_W'(NUM_PINS));
  assign tbl_idx_o = raw_idx[IDX_W-1:0];
  assign tbl_hi_o  = sel_i[0];

  always_comb begin
    tgt_o = TGT_NONE;
    if (in_tbl)                tgt_o = TGT_TBL;
    else if (sel_i == SEL_ID)  tgt_o = TGT_ID;
    else if (sel_i == SEL_VER) tgt_o = TGT_VER;
    else if (sel_i == SEL_ARB) tgt_o = TGT_ARB;
  end

  assign sel_we_o = wr_ok && hit_sel_o;
  assign id_we_o  = wr_ok && hit_win_o && (tgt_o == TGT_ID);
  assign tbl_we_o = wr_ok && hit_win_o && (tgt_o == TGT_TBL);
endmodule

// File: rtl/ioirq_table.sv
module ioirq_table
  import ioirq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic                               hi_i,
  input  logic [IDX_W-1:0]                   idx_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic [NUM_PINS-1:0]                rirr_set_i,
  output logic [NUM_PINS-1:0][ENTRY_W-1:0]   ent_o
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_o[g] <= ENTRY_RST;
      end else begin
        if (rirr_set_i[g]) ent_o[g][RIRR_BIT] <= 1'b1;
        if (hit) begin
          if (hi_i) begin
            ent_o[g][ENTRY_W-1:DATA_W] <= wdata_i;
          end else begin
            ent_o[g][DATA_W-1:0] <= wdata_i;
            // low-half write always drops the remote flag, also over a same-cycle set
            ent_o[g][RIRR_BIT]   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ioirq_rdmux.sv
module ioirq_rdmux
  import ioirq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned IDX_W    = $clog2(NUM_PINS),
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                             hit_sel_i,
  input  logic                             hit_win_i,
  input  tgt_e                             tgt_i,
  input  logic                             hi_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [SEL_W-1:0]                 sel_i,
  input  logic [ID_W-1:0]                  id_i,
  input  logic [NUM_PINS-1:0][ENTRY_W-1:0] ent_i,
  output logic [DATA_W-1:0]                rdata_o
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);

  always_comb begin
    rdata_o = '0;
    if (hit_sel_i) begin
      rdata_o[SEL_W-1:0] = sel_i;
    end else if (hit_win_i) begin
      unique case (tgt_i)
        TGT_ID, TGT_ARB: rdata_o[ID_LSB+:ID_W] = id_i;
        TGT_VER: begin
          rdata_o[23:16] = MAX_PIN;
          rdata_o[7:0]   = VERSION;
        end
        TGT_TBL: rdata_o = hi_i ? ent_i[idx_i][ENTRY_W-1:DATA_W] : ent_i[idx_i][DATA_W-1:0];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ioirq_regwin.sv
module ioirq_regwin
  import ioirq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  input  logic                          req_write_i,
  input  logic [7:0]                    req_addr_i,
  input  logic [3:0]                    req_size_i,
  input  logic [31:0]                   req_wdata_i,
  output logic                          rd_valid_o,
  output logic [31:0]                   rd_data_o,
  input  logic [NUM_PINS-1:0]           pend_i,
  input  logic [NUM_PINS-1:0]           rirr_set_i,
  output logic [NUM_PINS*64-1:0]        entries_o,
  output logic                          svc_req_o,
  output logic [$clog2(NUM_PINS)-1:0]   svc_idx_o
);
  localparam int unsigned IDX_W = $clog2(NUM_PINS);

  logic [SEL_W-1:0]                 sel_q;
  logic [ID_W-1:0]                  id_q;
  logic [NUM_PINS-1:0][ENTRY_W-1:0] ent;
  tgt_e                             tgt;
  logic                             hit_sel, hit_win, rd_en;
  logic                             sel_we, id_we, tbl_we, tbl_hi;
  logic [IDX_W-1:0]                 tbl_idx;
  logic [DATA_W-1:0]                rdata;

  ioirq_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .addr_i    (req_addr_i),
    .size_i    (req_size_i),
    .sel_i     (sel_q),
    .tgt_o     (tgt),
    .hit_sel_o (hit_sel),
    .hit_win_o (hit_win),
    .rd_en_o   (rd_en),
    .sel_we_o  (sel_we),
    .id_we_o   (id_we),
    .tbl_we_o  (tbl_we),
    .tbl_hi_o  (tbl_hi),
    .tbl_idx_o (tbl_idx)
  );

  ioirq_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we),
    .hi_i       (tbl_hi),
    .idx_i      (tbl_idx),
    .wdata_i    (req_wdata_i),
    .rirr_set_i (rirr_set_i),
    .ent_o      (ent)
  );

  ioirq_rdmux #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rd (
    .hit_sel_i (hit_sel),
    .hit_win_i (hit_win),
    .tgt_i     (tgt),
    .hi_i      (tbl_hi),
    .idx_i     (tbl_idx),
    .sel_i     (sel_q),
    .id_i      (id_q),
    .ent_i     (ent),
    .rdata_o   (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= '0;
      id_q       <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      svc_req_o  <= 1'b0;
      svc_idx_o  <= '0;
    end else begin
      if (sel_we) sel_q <= req_wdata_i[SEL_W-1:0];
      if (id_we)  id_q  <= req_wdata_i[ID_LSB+:ID_W];
      rd_valid_o <= rd_en;
      if (rd_en) rd_data_o <= rdata;
      svc_req_o <= tbl_we && pend_i[tbl_idx];
      if (tbl_we) svc_idx_o <= tbl_idx;
    end
  end

  assign entries_o = ent;
endmodule

// File: rtl/ioirq_regwin_chk.sv
module ioirq_regwin_chk #(
  parameter int unsigned NUM_PINS = 24,
  parameter logic [7:0]  VERSION  = 8'h11
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_write_i,
  input logic [7:0]            req_addr_i,
  input logic [3:0]            req_size_i,
  input logic                  rd_valid_o,
  input logic [31:0]           rd_data_o,
  input logic [NUM_PINS-1:0]   rirr_set_i,
  input logic [NUM_PINS*64-1:0] entries_o,
  input logic                  svc_req_o,
  input logic [7:0]            sel_q,
  input logic [3:0]            id_q
);
  logic size_ok, win_wr, lo_wr;
  logic lo_wr_q;
  logic [7:0] lo_idx, lo_idx_q;

  assign size_ok = (req_size_i == 4'd4) || (req_size_i == 4'd8);
  assign win_wr  = req_valid_i && req_write_i && size_ok && (req_addr_i == 8'h10);
  assign lo_idx  = 8'((sel_q - 8'h10) >> 1);
  assign lo_wr   = win_wr && (sel_q >= 8'h10) && !sel_q[0] && (lo_idx < 8'(NUM_PINS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_wr_q  <= 1'b0;
      lo_idx_q <= '0;
    end else begin
      lo_wr_q  <= lo_wr;
      lo_idx_q <= lo_idx;
    end
  end

  assert_svc_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_req_o |-> $past(win_wr));

  assert_rd_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(req_valid_i && !req_write_i));

  assert_ver_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(req_addr_i == 8'h10 && sel_q == 8'h01))
      |-> (rd_data_o == {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION}));

  assert_lo_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_q |-> (entries_o[32'(lo_idx_q) * 64 + 14] == 1'b0));

  assert_bad_size_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !size_ok && (rirr_set_i == '0))
      |=> ($stable(entries_o) && $stable(sel_q) && $stable(id_q)));

  assert_arb_ro_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_wr && sel_q == 8'h02) |=> $stable(id_q));
endmodule

bind ioirq_regwin ioirq_regwin_chk #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .rirr_set_i  (rirr_set_i),
  .entries_o   (entries_o),
  .svc_req_o   (svc_req_o),
  .sel_q       (sel_q),
  .id_q        (id_q)
);

// File: tb/ioirq_regwin_tb.sv
`timescale 1ns/1ps
module ioirq_regwin_tb_top;
  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [3:0]    req_size = '0;
  logic [31:0]   req_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NP-1:0] pend = '0;
  logic [NP-1:0] rset = '0;
  logic [NP*64-1:0] entries;
  logic          svc_req;
  logic [4:0]    svc_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] m_ent [NP];
  logic [3:0]  m_id;
  logic [7:0]  m_sel;

  always #4 clk = ~clk;

  ioirq_regwin dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .pend_i(pend), .rirr_set_i(rset),
    .entries_o(entries), .svc_req_o(svc_req), .svc_idx_o(svc_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [7:0] i;
    if (a == 8'h00) return {24'd0, m_sel};
    if (a != 8'h10) return 32'd0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'd0, m_id, 24'd0};
    if (m_sel == 8'h01) return {8'd0, 8'(NP - 1), 8'd0, 8'h11};
    if (m_sel < 8'h10) return 32'd0;
    i = (m_sel - 8'h10) >> 1;
    if (i >= 8'(NP)) return 32'd0;
    return m_sel[0] ? m_ent[i][63:32] : m_ent[i][31:0];
  endfunction

  // returns expected service request; updates model
  function automatic bit m_write(input logic [7:0] a, input logic [3:0] sz, input logic [31:0] d,
                                 input logic [NP-1:0] pd, output logic [4:0] sidx);
    logic [7:0] i;
    sidx = '0;
    if (!(sz == 4'd4 || sz == 4'd8)) return 1'b0;
    if (a == 8'h00) begin m_sel = d[7:0]; return 1'b0; end
    if (a != 8'h10) return 1'b0;
    if (m_sel == 8'h00) begin m_id = d[27:24]; return 1'b0; end
    if (m_sel < 8'h10) return 1'b0;
    i = (m_sel - 8'h10) >> 1;
    if (i >= 8'(NP)) return 1'b0;
    if (m_sel[0]) m_ent[i][63:32] = d;
    else begin m_ent[i][31:0] = d; m_ent[i][14] = 1'b0; end
    sidx = i[4:0];
    return pd[i];
  endfunction

  task automatic access(input bit wr, input logic [7:0] a, input logic [3:0] sz,
                        input logic [31:0] d, input logic [NP-1:0] pd, input logic [NP-1:0] rs,
                        input string req);
    logic [31:0] exp_rd;
    bit          exp_svc;
    logic [4:0]  exp_idx;
    exp_rd = m_read(a);
    for (int p = 0; p < NP; p++) if (rs[p]) m_ent[p][14] = 1'b1;
    exp_svc = wr ? m_write(a, sz, d, pd, exp_idx) : 1'b0;
    if (!wr) exp_idx = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = d; pend = pd; rset = rs;
    @(negedge clk);
    req_valid = 1'b0; rset = '0;
    chk(rd_valid == !wr, {req, " R11 rd_valid"}, 64'(rd_valid), 64'(!wr));
    if (!wr) chk(rd_data == exp_rd, {req, " read data"}, 64'(rd_data), 64'(exp_rd));
    chk(svc_req == exp_svc, {req, " R9 svc_req"}, 64'(svc_req), 64'(exp_svc));
    if (exp_svc) chk(svc_idx == exp_idx, {req, " R9 svc_idx"}, 64'(svc_idx), 64'(exp_idx));
  endtask

  task automatic chk_table(input string req);
    bit ok = 1;
    int first = -1;
    for (int p = 0; p < NP; p++)
      if (entries[p*64 +: 64] !== m_ent[p]) begin ok = 0; if (first < 0) first = p; end
    if (first < 0) first = 0;
    chk(ok, {req, " table image"}, entries[first*64 +: 64], m_ent[first]);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    access(1'b1, a, 4'd4, d, '0, '0, req);
  endtask
  task automatic rd(input logic [7:0] a, input string req);
    access(1'b0, a, 4'd4, 32'd0, '0, '0, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) m_ent[p] = 64'd1 << 16;
    m_id = '0; m_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(svc_req == 1'b0, "R1 svc after reset", 64'(svc_req), 0);
    chk_table("R1");
    rd(8'h00, "R1 R2 select reset");
    rd(8'h10, "R1 R4 id reset");

    // R2 select register
    wr(8'h00, 32'hFFFF_FF2B, "R2 select write");
    rd(8'h00, "R2 select read");

    // R3 version
    wr(8'h00, 32'h01, "R3 sel");
    rd(8'h10, "R3 version read");
    wr(8'h10, 32'hFFFF_FFFF, "R3 version write");
    rd(8'h10, "R3 version after write");
    chk_table("R3");

    // R4 id
    wr(8'h00, 32'h00, "R4 sel");
    wr(8'h10, 32'hA5FF_FFFF, "R4 id write");
    rd(8'h10, "R4 id read");

    // R5 arbitration
    wr(8'h00, 32'h02, "R5 sel");
    rd(8'h10, "R5 arb read");
    wr(8'h10, 32'h3000_0000, "R5 arb write");
    rd(8'h10, "R5 arb after write");
    wr(8'h00, 32'h00, "R5 sel id");
    rd(8'h10, "R5 id unchanged");

    // R6 mapping: first, last, past end
    wr(8'h00, 32'h10, "R6 sel lo0");
    wr(8'h10, 32'h1234_5678, "R6 lo0 write");
    wr(8'h00, 32'h11, "R6 sel hi0");
    wr(8'h10, 32'h9ABC_DEF0, "R6 hi0 write");
    rd(8'h10, "R6 hi0 read");
    wr(8'h00, 32'h3E, "R6 sel lo23");
    wr(8'h10, 32'h0000_00C3, "R6 lo23 write");
    wr(8'h00, 32'h3F, "R6 sel hi23");
    wr(8'h10, 32'hFF00_0000, "R6 hi23 write");
    rd(8'h10, "R6 hi23 read");
    chk_table("R6");
    wr(8'h00, 32'h40, "R6 sel past");
    wr(8'h10, 32'hDEAD_BEEF, "R6 past write");
    rd(8'h10, "R6 past read");
    chk_table("R6 past");

    // R7 R8 remote flag
    access(1'b1, 8'h00, 4'd4, 32'h15, '0, 24'h000004, "R8 strobe pin2");
    chk_table("R8 set");
    wr(8'h10, 32'h0000_0000, "R7 hi write keeps flag");
    chk_table("R7 hi");
    wr(8'h00, 32'h14, "R7 sel lo2");
    wr(8'h10, 32'hFFFF_FFFF, "R7 lo write clears flag");
    chk_table("R7 lo");
    access(1'b1, 8'h10, 4'd8, 32'h0000_4000, '0, 24'h000004, "R8 collision");
    chk_table("R8 collision");

    // R9 service
    access(1'b1, 8'h10, 4'd4, 32'h55, 24'h000004, '0, "R9 pending pin2");
    access(1'b1, 8'h10, 4'd4, 32'h66, 24'hFFFFFB, '0, "R9 other pins pending");
    access(1'b0, 8'h10, 4'd4, 32'h0, 24'hFFFFFF, '0, "R9 read no svc");

    // R10 sizes
    access(1'b1, 8'h10, 4'd2, 32'h7777, 24'hFFFFFF, '0, "R10 size2");
    access(1'b1, 8'h10, 4'd1, 32'h77, 24'hFFFFFF, '0, "R10 size1");
    access(1'b1, 8'h00, 4'd2, 32'h01, '0, '0, "R10 size2 select");
    rd(8'h00, "R10 select kept");
    chk_table("R10");

    // R11 unknown offsets and reserved select
    rd(8'h20, "R11 offset 0x20");
    rd(8'h14, "R11 offset 0x14");
    wr(8'h00, 32'h05, "R11 sel 5");
    rd(8'h10, "R11 reserved select read");

    // random
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [3:0] sz;
      int k = $urandom_range(0, 9);
      a = (k < 3) ? 8'h00 : (k < 9) ? 8'h10 : 8'($urandom_range(0, 255));
      sz = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'd4;
      if (a == 8'h00 && $urandom_range(0, 1) == 1)
        access(1'b1, a, sz, 32'($urandom_range(0, 8'h45)), 24'($urandom), '0, "R6 rnd sel");
      else
        access($urandom_range(0, 1) == 1, a, sz, $urandom, 24'($urandom),
               ($urandom_range(0, 3) == 0) ? 24'($urandom) : '0, "R6 rnd");
      if (n % 50 == 0) chk_table("R8 rnd");
    end
    chk_table("R8 final");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule